// File: doc/BRIEF.md
# Tagged Custom-Instruction Dispatcher

This block sits beside a processor pipeline and serves custom instructions from a small array of operation rows. Each row holds a tag naming the custom operation it implements, plus a function code that picks a combinational compute function. The function works on three live register-file operands and on the result of the row below it. When the pipeline issues a custom opcode, the dispatcher looks the tag up across all loaded rows. On a hit, it stalls the pipeline for that row's latency and then drives the row's result onto the writeback bus. On a miss, it keeps the stall asserted and raises a miss flag until a loader writes a row carrying the missing tag. The operation then executes from that newly written row.

The control path is a three-state machine. ST_IDLE waits for an issue. ST_EXEC counts down the selected row's latency. ST_MISS waits for the missing tag to be loaded. The transitions are:
- HIT_ACCEPT (ST_IDLE to ST_EXEC): the issue hits a row.
- MISS_ENTER (ST_IDLE to ST_MISS): no row holds the tag.
- LOAD_RESOLVE (ST_MISS to ST_EXEC): a load writes the pending tag.
- RESULT_DONE (ST_EXEC to ST_IDLE): the count expires and writeback fires.

Every other cycle holds the current state.

Row r has latency LAT_BASE + r*LAT_STEP cycles, counted from the cycle in which the operation is accepted or resolved. The rows keep no operand state. The result always reflects the operand values present in the writeback cycle.

Top module: `ciu_dispatch`

## Requirements
- R1: Reset clears every row to unloaded with function code 0, and holds stall, miss and wb_valid low. The first issue after reset misses.
- R2: An issue in ST_IDLE whose tag hits row r raises stall in the issue cycle. Stall stays high for the following LAT_BASE + r*LAT_STEP - 1 cycles. In the cycle LAT_BASE + r*LAT_STEP after the issue, wb_valid is high and stall is low.
- R3: The row result follows the function code. Code 0 gives a+b+c. Code 1 gives a^b^c. Code 2 gives a*b+c. Code 3 gives the result of row r-1 plus a, with row 0 using zero as its lower input. All arithmetic is modulo 2^W.
- R4: wb_data is computed from the operand values present in the writeback cycle, not from those present at issue.
- R5: When several loaded rows hold the issued tag, the lowest-numbered row serves it.
- R6: An issue whose tag is in no loaded row raises stall in the issue cycle. miss and stall are then high from the next cycle onward.
- R7: While miss is high, a load with a different tag leaves miss high. A load whose tag equals the pending tag drops miss in the next cycle. The operation then completes from the loaded row, with wb_valid high LAT_BASE + r*LAT_STEP cycles after the load cycle.
- R8: A load replaces a row's tag and function code in one cycle. Later issues use the new function, and the row's old tag no longer hits in it.
- R9: stall and wb_valid are never high together, and wb_valid never stays high for two consecutive cycles.
- R10: An issue presented in the cycle right after a writeback is accepted, with stall high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Custom operation issued; held by the pipeline while stall is high |
| issue_tag | input | TAGW | Custom opcode tag of the issued operation |
| opnd_a | input | W | Live register operand A |
| opnd_b | input | W | Live register operand B |
| opnd_c | input | W | Live register operand C |
| ld_valid | input | 1 | Row load strobe |
| ld_row | input | IDXW | Row index to load |
| ld_tag | input | TAGW | Tag written into the row |
| ld_fsel | input | 2 | Function code written into the row |
| stall | output | 1 | Hold the pipeline |
| miss | output | 1 | Issued tag is not loaded in any row |
| wb_valid | output | 1 | Writeback strobe, one cycle |
| wb_data | output | W | Writeback result, zero when wb_valid is low |

## Verification
The assertions check the following on every cycle:
- stall and wb_valid never overlap, and writeback is a single-cycle pulse.
- Every writeback follows a stalled cycle.
- The latency counter steps down by exactly one.
- miss always implies stall, and miss holds until a load names the pending tag, then clears.

The bench scenarios cover the behaviours that need a reference model:
- the computed values of each function and of chained rows;
- priority among duplicate tags;
- the exact writeback cycle for each row's latency;
- results that follow operands changed during the stall;
- tags that stop hitting after a row is overwritten.

// File: rtl/ciu_pkg.sv
package ciu_pkg;

    typedef enum logic [1:0] {
        FN_SUM3   = 2'd0,
        FN_XOR3   = 2'd1,
        FN_MULADD = 2'd2,
        FN_CHAIN  = 2'd3
    } fsel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_MISS = 2'd2
    } state_e;

endpackage

// File: rtl/ciu_row_table.sv
module ciu_row_table
    import ciu_pkg::*;
#(
    parameter int NROWS = 4,
    parameter int TAGW  = 4,
    parameter int IDXW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [IDXW-1:0]  ld_row,
    input  logic [TAGW-1:0]  ld_tag,
    input  fsel_e            ld_fsel,
    input  logic [TAGW-1:0]  look_tag,
    output logic             hit,
    output logic [IDXW-1:0]  hit_idx,
    output fsel_e            row_fsel [NROWS]
);

    logic [NROWS-1:0] row_vld;
    logic [TAGW-1:0]  row_tag [NROWS];
    logic [NROWS-1:0] match;

    for (genvar g = 0; g < NROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_vld[g]  <= 1'b0;
                row_tag[g]  <= '0;
                row_fsel[g] <= FN_SUM3;
            end else if (ld_valid && (ld_row == IDXW'(g))) begin
                row_vld[g]  <= 1'b1;
                row_tag[g]  <= ld_tag;
                row_fsel[g] <= ld_fsel;
            end
        end

        assign match[g] = row_vld[g] && (row_tag[g] == look_tag);
    end

    // Lowest-numbered matching row wins: scan downward so the last write is the lowest index.
    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = NROWS - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/ciu_row_unit.sv
module ciu_row_unit
    import ciu_pkg::*;
#(
    parameter int W = 16
) (
    input  fsel_e        fsel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] chain_in,
    output logic [W-1:0] result
);

    always_comb begin
        unique case (fsel)
            FN_SUM3:   result = a + b + c;
            FN_XOR3:   result = a ^ b ^ c;
            FN_MULADD: result = (a * b) + c;
            FN_CHAIN:  result = chain_in + a;
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/ciu_lat_counter.sv
module ciu_lat_counter #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          zero
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ciu_dispatch.sv
module ciu_dispatch
    import ciu_pkg::*;
#(
    parameter int NROWS    = 4,
    parameter int W        = 16,
    parameter int TAGW     = 4,
    parameter int LAT_BASE = 2,
    parameter int LAT_STEP = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                issue_valid,
    input  logic [TAGW-1:0]                     issue_tag,
    input  logic [W-1:0]                        opnd_a,
    input  logic [W-1:0]                        opnd_b,
    input  logic [W-1:0]                        opnd_c,
    input  logic                                ld_valid,
    input  logic [((NROWS > 1) ? $clog2(NROWS) : 1)-1:0] ld_row,
    input  logic [TAGW-1:0]                     ld_tag,
    input  logic [1:0]                          ld_fsel,
    output logic                                stall,
    output logic                                miss,
    output logic                                wb_valid,
    output logic [W-1:0]                        wb_data
);

    localparam int IDXW   = (NROWS > 1) ? $clog2(NROWS) : 1;
    localparam int MAXLAT = LAT_BASE + (NROWS - 1) * LAT_STEP;
    localparam int CW     = $clog2(MAXLAT + 1);

    state_e            state_q, state_d;
    logic [TAGW-1:0]   pend_tag_q, pend_tag_d;
    logic [IDXW-1:0]   sel_row_q, sel_row_d;
    logic              cnt_load;
    logic [CW-1:0]     cnt_load_val;
    logic [CW-1:0]     cnt_q;
    logic              cnt_zero;
    logic              hit;
    logic [IDXW-1:0]   hit_idx;
    fsel_e             row_fsel [NROWS];
    logic [W-1:0]      row_res  [NROWS];

    ciu_row_table #(.NROWS(NROWS), .TAGW(TAGW), .IDXW(IDXW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_row   (ld_row),
        .ld_tag   (ld_tag),
        .ld_fsel  (fsel_e'(ld_fsel)),
        .look_tag (issue_tag),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .row_fsel (row_fsel)
    );

    for (genvar g = 0; g < NROWS; g++) begin : g_unit
        logic [W-1:0] chain_in;
        if (g == 0) begin : g_base
            assign chain_in = '0;
        end else begin : g_link
            assign chain_in = row_res[g-1];
        end
        ciu_row_unit #(.W(W)) u_unit (
            .fsel     (row_fsel[g]),
            .a        (opnd_a),
            .b        (opnd_b),
            .c        (opnd_c),
            .chain_in (chain_in),
            .result   (row_res[g])
        );
    end

    ciu_lat_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .cnt      (cnt_q),
        .zero     (cnt_zero)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_tag_q <= '0;
            sel_row_q  <= '0;
        end else begin
            state_q    <= state_d;
            pend_tag_q <= pend_tag_d;
            sel_row_q  <= sel_row_d;
        end
    end

    // Next state: HIT_ACCEPT, MISS_ENTER, LOAD_RESOLVE, RESULT_DONE
    always_comb begin
        state_d      = state_q;
        pend_tag_d   = pend_tag_q;
        sel_row_d    = sel_row_q;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (hit) begin
                        state_d      = ST_EXEC;
                        sel_row_d    = hit_idx;
                        cnt_load     = 1'b1;
                        cnt_load_val = CW'(LAT_BASE - 1 + int'(hit_idx) * LAT_STEP);
                    end else begin
                        state_d    = ST_MISS;
                        pend_tag_d = issue_tag;
                    end
                end
            end
            ST_EXEC: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            ST_MISS: begin
                if (ld_valid && (ld_tag == pend_tag_q)) begin
                    state_d      = ST_EXEC;
                    sel_row_d    = ld_row;
                    cnt_load     = 1'b1;
                    cnt_load_val = CW'(LAT_BASE - 1 + int'(ld_row) * LAT_STEP);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stall    = 1'b0;
        miss     = 1'b0;
        wb_valid = 1'b0;
        wb_data  = '0;
        unique case (state_q)
            ST_IDLE: stall = issue_valid;
            ST_EXEC: begin
                if (cnt_zero) begin
                    wb_valid = 1'b1;
                    wb_data  = row_res[sel_row_q];
                end else begin
                    stall = 1'b1;
                end
            end
            ST_MISS: begin
                stall = 1'b1;
                miss  = 1'b1;
            end
            default: stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/ciu_dispatch_chk.sv
module ciu_dispatch_chk #(
    parameter int TAGW = 4,
    parameter int CW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ld_valid,
    input logic [TAGW-1:0] ld_tag,
    input logic            stall,
    input logic            miss,
    input logic            wb_valid,
    input logic [TAGW-1:0] pend_tag,
    input logic [CW-1:0]   cnt
);

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && wb_valid));

    assert_wb_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    assert_wb_after_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(stall));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_miss_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> stall);

    assert_miss_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !(ld_valid && ld_tag == pend_tag)) |=> miss);

    assert_miss_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && ld_valid && ld_tag == pend_tag) |=> !miss);

endmodule

bind ciu_dispatch ciu_dispatch_chk #(.TAGW(TAGW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_tag   (ld_tag),
    .stall    (stall),
    .miss     (miss),
    .wb_valid (wb_valid),
    .pend_tag (pend_tag_q),
    .cnt      (cnt_q)
);

// File: tb/ciu_dispatch_tb.sv
module ciu_dispatch_tb;

    localparam int NROWS = 4;
    localparam int W     = 16;
    localparam int TAGW  = 4;
    localparam int LB    = 2;
    localparam int LS    = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid = 1'b0;
    logic [TAGW-1:0] issue_tag = '0;
    logic [W-1:0]    opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic            ld_valid = 1'b0;
    logic [1:0]      ld_row = '0;
    logic [TAGW-1:0] ld_tag = '0;
    logic [1:0]      ld_fsel = '0;
    logic            stall, miss, wb_valid;
    logic [W-1:0]    wb_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic            m_vld  [NROWS];
    logic [TAGW-1:0] m_tag  [NROWS];
    logic [1:0]      m_fsel [NROWS];

    always #4 clk = ~clk;

    ciu_dispatch #(.NROWS(NROWS), .W(W), .TAGW(TAGW), .LAT_BASE(LB), .LAT_STEP(LS)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_tag(issue_tag),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .ld_valid(ld_valid),
        .ld_row(ld_row), .ld_tag(ld_tag), .ld_fsel(ld_fsel), .stall(stall),
        .miss(miss), .wb_valid(wb_valid), .wb_data(wb_data)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lat(int r);
        return LB + r * LS;
    endfunction

    function automatic logic [W-1:0] ref_row(int r, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] prev = '0;
        logic [W-1:0] v;
        for (int i = 0; i <= r; i++) begin
            case (m_fsel[i])
                2'd0:    v = a + b + c;
                2'd1:    v = a ^ b ^ c;
                2'd2:    v = (a * b) + c;
                default: v = prev + a;
            endcase
            prev = v;
        end
        return prev;
    endfunction

    function automatic int ref_hit(logic [TAGW-1:0] t);
        for (int i = 0; i < NROWS; i++) begin
            if (m_vld[i] && m_tag[i] == t) return i;
        end
        return -1;
    endfunction

    task automatic model_load(int r, logic [TAGW-1:0] t, logic [1:0] f);
        m_vld[r]  = 1'b1;
        m_tag[r]  = t;
        m_fsel[r] = f;
    endtask

    // Idle-time row load.
    task automatic load_row(int r, logic [TAGW-1:0] t, logic [1:0] f);
        @(negedge clk);
        ld_valid = 1'b1; ld_row = 2'(r); ld_tag = t; ld_fsel = f;
        @(negedge clk);
        ld_valid = 1'b0;
        model_load(r, t, f);
    endtask

    // Called at the negedge of the accept/resolve cycle; checks through writeback.
    task automatic finish_op(int r, string req, bit chg, logic [W-1:0] na, logic [W-1:0] nb, logic [W-1:0] nc);
        for (int k = 1; k < lat(r); k++) begin
            @(negedge clk);
            issue_valid = 1'b0; ld_valid = 1'b0;
            #1;
            chk({req, " stall during latency"}, {31'd0, stall}, 32'd1);
            chk({req, " no early wb"}, {31'd0, wb_valid}, 32'd0);
            chk("R7 miss low after accept", {31'd0, miss}, 32'd0);
        end
        @(negedge clk);
        issue_valid = 1'b0; ld_valid = 1'b0;
        if (chg) begin
            opnd_a = na; opnd_b = nb; opnd_c = nc;
        end
        #1;
        chk({req, " R9 wb_valid at latency"}, {31'd0, wb_valid}, 32'd1);
        chk({req, " R9 stall low at wb"}, {31'd0, stall}, 32'd0);
        chk({req, " R3 wb_data"}, {16'd0, wb_data}, {16'd0, ref_row(r, opnd_a, opnd_b, opnd_c)});
    endtask

    // Issue, optionally resolve a miss by loading row lr with function lf after dly cycles.
    task automatic do_op(logic [TAGW-1:0] t, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                         int dly, int lr, logic [1:0] lf, bit wrong, string req);
        int r;
        @(negedge clk);
        issue_valid = 1'b1; issue_tag = t; opnd_a = a; opnd_b = b; opnd_c = c;
        #1;
        chk("R2 R10 stall in issue cycle", {31'd0, stall}, 32'd1);
        r = ref_hit(t);
        if (r >= 0) begin
            finish_op(r, req, 1'b0, '0, '0, '0);
        end else begin
            for (int d = 0; d < dly; d++) begin
                @(negedge clk); #1;
                chk("R6 miss raised", {31'd0, miss}, 32'd1);
                chk("R6 stall held on miss", {31'd0, stall}, 32'd1);
            end
            if (wrong) begin
                @(negedge clk);
                ld_valid = 1'b1; ld_row = 2'((lr + 1) % NROWS); ld_tag = t ^ 4'h8; ld_fsel = 2'd0;
                @(negedge clk);
                ld_valid = 1'b0;
                model_load((lr + 1) % NROWS, t ^ 4'h8, 2'd0);
                #1;
                chk("R7 wrong-tag load keeps miss", {31'd0, miss}, 32'd1);
            end
            @(negedge clk);
            ld_valid = 1'b1; ld_row = 2'(lr); ld_tag = t; ld_fsel = lf;
            #1;
            chk("R6 miss before resolve", {31'd0, miss}, 32'd1);
            model_load(lr, t, lf);
            finish_op(lr, "R7 resolved", 1'b0, '0, '0, '0);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < NROWS; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_fsel[i] = 2'd0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1 stall low at reset", {31'd0, stall}, 32'd0);
        chk("R1 miss low at reset", {31'd0, miss}, 32'd0);
        chk("R1 wb_valid low at reset", {31'd0, wb_valid}, 32'd0);
        rst_n = 1'b1;

        // R1/R6/R7: empty table misses; resolve into row 2 with XOR
        do_op(4'h5, 16'h1234, 16'h00ff, 16'h0f0f, 2, 2, 2'd1, 1'b1, "R1");

        // R3: each function
        load_row(0, 4'h1, 2'd0);
        load_row(1, 4'h2, 2'd2);
        load_row(3, 4'h3, 2'd3);
        do_op(4'h1, 16'hfff0, 16'h0020, 16'h0003, 0, 0, 2'd0, 1'b0, "R3 sum");
        do_op(4'h2, 16'h0123, 16'h0456, 16'h0789, 0, 0, 2'd0, 1'b0, "R3 muladd");
        do_op(4'h3, 16'h1111, 16'h2222, 16'h4444, 0, 0, 2'd0, 1'b0, "R3 chain");
        do_op(4'h5, 16'haaaa, 16'h5555, 16'h0f0f, 0, 0, 2'd0, 1'b0, "R3 xor");

        // R5: duplicate tag, lowest row wins
        load_row(2, 4'h1, 2'd1);
        do_op(4'h1, 16'h0f00, 16'h00f0, 16'h000f, 0, 0, 2'd0, 1'b0, "R5 dup low row");
        // R8: overwrite row 0; tag 1 now served by row 2
        load_row(0, 4'h9, 2'd2);
        do_op(4'h1, 16'h0f00, 16'h0ff0, 16'h000f, 0, 0, 2'd0, 1'b0, "R5 R8 after overwrite");
        // R8: old tag of row 1 stops hitting
        load_row(1, 4'h7, 2'd0);
        do_op(4'h2, 16'h0003, 16'h0005, 16'h0007, 1, 1, 2'd2, 1'b1, "R8 old tag misses");

        // R4: operands change during stall; result follows writeback-cycle values
        @(negedge clk);
        issue_valid = 1'b1; issue_tag = 4'h9; opnd_a = 16'h0002; opnd_b = 16'h0003; opnd_c = 16'h0001;
        #1;
        chk("R4 stall in issue", {31'd0, stall}, 32'd1);
        finish_op(ref_hit(4'h9), "R4 live operands", 1'b1, 16'h0010, 16'h0011, 16'h0100);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                load_row(int'($urandom_range(0, NROWS - 1)), 4'($urandom()), 2'($urandom()));
            end else begin
                do_op(4'($urandom()), 16'($urandom()), 16'($urandom()), 16'($urandom()),
                      int'($urandom_range(0, 3)), int'($urandom_range(0, NROWS - 1)),
                      2'($urandom()), 1'($urandom()), "R2 random");
            end
        end

        @(negedge clk); #1;
        chk("R9 idle after run", {31'd0, wb_valid}, 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule